// File: doc/BRIEF.md
# Bus Width Adapter With Wait States

The adapter lets a 32-bit processor bus reach narrow external devices. It decodes the top address bits into one of several regions. Each region has a fixed device width of 8 or 16 bits and its own wait-state count from 0 to 7. A 32-bit request is broken into the narrow device cycles that cover its enabled byte lanes. Read data from those cycles is gathered back into one 32-bit word. Writes to the boot ROM region are blocked in hardware unless a flash-enable bit in that region's configuration register is set.

The processor side uses a valid/ready pair and has one request outstanding at a time. The processor raises `cpu_valid` and holds the address, direction, byte enables and write data unchanged until it sees `cpu_ready`. `cpu_ready` is a one-cycle completion pulse, and `cpu_rdata` is valid in that same cycle. The adapter applies back-pressure only by delaying `cpu_ready`. The processor drops `cpu_valid`, or presents a new request, after the pulse. The device side is plain: one chip-select per region, read and write strobes, a byte address, 16-bit data lines and two byte strobes.

Top module: `bwa_bridge`

## Requirements
- R1: Region decode uses the address nibble `cpu_addr[23:20]`:
  - 0–1 is ROM (16-bit, `dev_cs[0]`).
  - 2–3 is RAM (8-bit, `dev_cs[1]`).
  - 4 is the configuration registers.
  - 5 is the peripheral area (16-bit, `dev_cs[2]`).
  - 6–7 is external select A (8-bit, `dev_cs[3]`).
  - 8–9 is external select B (8-bit, `dev_cs[4]`).
  - 10–15 is unused.
- R2: In a 16-bit region, each device cycle carries one halfword, lower halfword first.
  - `dev_addr` is the word address plus 0, then plus 2.
  - Write data is placed on `dev_wdata[15:0]`.
  - `dev_be` copies the two CPU byte enables of that halfword.
- R3: In an 8-bit region, each device cycle carries one byte, least significant byte first.
  - `dev_addr` is the word address plus the byte index.
  - Write data is placed on `dev_wdata[7:0]`, with `dev_be`=01.
- R4: Only units with at least one enabled byte lane get a device cycle. A request with `cpu_be`=0 makes no device cycle and completes in the first cycle.
- R5: Each device cycle holds its chip-select, strobe, address and data for 1+N clocks, where N is the region's wait count.
  - Read data is taken in the last of those clocks.
  - `cpu_ready` comes one clock after the last unit, so a request with U units is acknowledged U·(1+N)+1 cycles after acceptance.
- R6: Assembled read data holds zero in every byte lane not covered by a device cycle. In 16-bit regions, both bytes of a fetched halfword are returned.
- R7: Configuration register k sits at `0x400000 + 4k`. The index k is 0 for ROM, 1 for RAM, 2 for peripheral, 3 for select A and 4 for select B.
  - Bits [2:0] hold the wait count. Bit 3 is the flash-enable bit and exists only in register 0.
  - After reset, every wait count is 7 and flash-enable is 0.
  - A write takes effect only when `cpu_be[0]` is set.
  - Other offsets read zero.
  - Configuration accesses complete in the first cycle.
- R8: While flash-enable is 0, a ROM write asserts no chip-select and no strobe. It completes in the first cycle, and the ROM contents stay unchanged.
- R9: While flash-enable is 1, ROM writes run as ordinary 16-bit device cycles.
- R10: An access to the unused region completes in the first cycle with zero read data and no device activity.
- R11: Outside device cycles, all chip-selects and strobes are low.
  - At most one chip-select is active at a time.
  - Read and write strobes are never high together.
  - `cpu_ready` never stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request completed (one-cycle pulse) |
| cpu_addr | input | 24 | Byte address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte lane enables |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| dev_cs | output | 5 | One-hot region chip-selects |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_addr | output | 24 | Device byte address |
| dev_be | output | 2 | Device byte strobes |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |

## Verification
Each kind of corruption shows up at the ports in a known way:
- A wrong pending-lane mask or unit pointer shows at once on `dev_addr` or `dev_be` in the cycle of the bad unit. It also moves the `cpu_ready` pulse by whole units.
- A miscounted wait counter shifts the change of `dev_addr` and the final acknowledge by single clocks.
- A corrupted configuration register first becomes visible as a changed cycle length on the next access to that region, or on readback of the register.
- A faulty capture lane becomes visible only in the read data returned at `cpu_ready`, which is why every read compares the whole 32-bit word.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  localparam int NUM_DEV = 5;

  typedef enum logic [2:0] {
    RG_ROM  = 3'd0,
    RG_RAM  = 3'd1,
    RG_PER  = 3'd2,
    RG_SELA = 3'd3,
    RG_SELB = 3'd4,
    RG_CFG  = 3'd5,
    RG_NONE = 3'd6
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_RESP
  } state_e;

  typedef struct packed {
    region_e region;
    logic    narrow8;
  } decode_t;

  // lowest set bit of a 4-bit lane mask
  function automatic logic [1:0] first_unit(input logic [3:0] m);
    first_unit = 2'd3;
    for (int i = 3; i >= 0; i--) begin
      if (m[i]) first_unit = 2'(i);
    end
  endfunction

endpackage

// File: rtl/bwa_decode.sv
module bwa_decode
  import bwa_pkg::*;
(
  input  logic [3:0] top_bits,
  output decode_t    dec
);

  always_comb begin
    dec.narrow8 = 1'b0;
    unique case (top_bits)
      4'h0, 4'h1: dec.region = RG_ROM;
      4'h2, 4'h3: begin
        dec.region  = RG_RAM;
        dec.narrow8 = 1'b1;
      end
      4'h4:       dec.region = RG_CFG;
      4'h5:       dec.region = RG_PER;
      4'h6, 4'h7: begin
        dec.region  = RG_SELA;
        dec.narrow8 = 1'b1;
      end
      4'h8, 4'h9: begin
        dec.region  = RG_SELB;
        dec.narrow8 = 1'b1;
      end
      default:    dec.region = RG_NONE;
    endcase
  end

endmodule

// File: rtl/bwa_unit_plan.sv
module bwa_unit_plan (
  input  logic [3:0] be,
  input  logic       narrow8,
  output logic [3:0] mask
);

  // 8-bit: one unit per enabled byte; 16-bit: one unit per touched halfword
  always_comb begin
    if (narrow8) mask = be;
    else         mask = {2'b00, |be[3:2], |be[1:0]};
  end

endmodule

// File: rtl/bwa_cfg_regs.sv
module bwa_cfg_regs #(
  parameter int NUM_DEV    = 5,
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_DEV)-1:0] wr_idx,
  input  logic [WAIT_W:0]            wr_data,
  input  logic [$clog2(NUM_DEV)-1:0] rd_idx,
  output logic [31:0]                rd_data,
  input  logic [$clog2(NUM_DEV)-1:0] sel_idx,
  output logic [WAIT_W-1:0]          sel_wait,
  output logic                       flash_en
);

  localparam int IDX_W = $clog2(NUM_DEV);

  logic [NUM_DEV-1:0][WAIT_W-1:0] wait_q;
  logic                           flash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DEV; i++) wait_q[i] <= WAIT_W'(RESET_WAIT);
      flash_q <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (wr_idx == IDX_W'(i)) wait_q[i] <= wr_data[WAIT_W-1:0];
      end
      if (wr_idx == '0) flash_q <= wr_data[WAIT_W];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data[WAIT_W-1:0] = wait_q[i];
    end
    if (rd_idx == '0) rd_data[WAIT_W] = flash_q;
  end

  always_comb begin
    sel_wait = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel_idx == IDX_W'(i)) sel_wait = wait_q[i];
    end
  end

  assign flash_en = flash_q;

  // R7: a register with be[0] clear or an out-of-range index keeps its value
  a_r7_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wait_q) && $stable(flash_q));

endmodule

// File: rtl/bwa_bridge.sv
module bwa_bridge
  import bwa_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int WAIT_W     = 3,
  parameter int RESET_WAIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic [NUM_DEV-1:0] dev_cs,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [1:0]        dev_be,
  output logic [15:0]       dev_wdata,
  input  logic [15:0]       dev_rdata
);

  localparam int HI    = ADDR_W - 1;
  localparam int IDX_W = $clog2(NUM_DEV);

  decode_t           dec;
  logic [3:0]        plan_mask;
  logic              cfg_wr;
  logic [31:0]       cfg_rdata;
  logic [WAIT_W-1:0] sel_wait;
  logic              flash_en;

  state_e            st;
  logic [HI:2]       cur_word;
  logic              cur_we;
  logic [3:0]        cur_be;
  logic [31:0]       cur_wdata;
  region_e           cur_region;
  logic              cur_n8;
  logic [3:0]        pend;
  logic [WAIT_W-1:0] wcnt;
  logic [WAIT_W-1:0] cur_wait;
  logic [31:0]       rbuf;

  logic [1:0]        unit;
  logic [3:0]        unit_bit;
  logic              last_unit;
  logic              xfer;
  logic              accept;
  logic              rom_blocked;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^cpu_addr[1:0];

  bwa_decode u_dec (
    .top_bits (cpu_addr[HI -: 4]),
    .dec      (dec)
  );

  bwa_unit_plan u_plan (
    .be      (cpu_be),
    .narrow8 (dec.narrow8),
    .mask    (plan_mask)
  );

  bwa_cfg_regs #(
    .NUM_DEV    (NUM_DEV),
    .WAIT_W     (WAIT_W),
    .RESET_WAIT (RESET_WAIT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_idx   (cpu_addr[IDX_W+1:2]),
    .wr_data  (cpu_wdata[WAIT_W:0]),
    .rd_idx   (cpu_addr[IDX_W+1:2]),
    .rd_data  (cfg_rdata),
    .sel_idx  (dec.region),
    .sel_wait (sel_wait),
    .flash_en (flash_en)
  );

  assign accept      = (st == ST_IDLE) && cpu_valid;
  assign cfg_wr      = accept && cpu_we && cpu_be[0] && (dec.region == RG_CFG);
  assign rom_blocked = cpu_we && (dec.region == RG_ROM) && !flash_en;

  assign unit      = first_unit(pend);
  assign unit_bit  = 4'b0001 << unit;
  assign last_unit = (pend & ~unit_bit) == 4'b0000;
  assign xfer      = (st == ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_word   <= '0;
      cur_we     <= 1'b0;
      cur_be     <= '0;
      cur_wdata  <= '0;
      cur_region <= RG_NONE;
      cur_n8     <= 1'b0;
      pend       <= '0;
      wcnt       <= '0;
      cur_wait   <= '0;
      rbuf       <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (cpu_valid) begin
            cur_word   <= cpu_addr[HI:2];
            cur_we     <= cpu_we;
            cur_be     <= cpu_be;
            cur_wdata  <= cpu_wdata;
            cur_region <= dec.region;
            cur_n8     <= dec.narrow8;
            cur_wait   <= sel_wait;
            wcnt       <= sel_wait;
            pend       <= '0;
            rbuf       <= '0;
            if (dec.region == RG_CFG) begin
              if (!cpu_we) rbuf <= cfg_rdata;
              st <= ST_RESP;
            end else if (dec.region == RG_NONE || rom_blocked || plan_mask == 4'b0000) begin
              st <= ST_RESP;
            end else begin
              pend <= plan_mask;
              st   <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (wcnt == '0) begin
            if (!cur_we) begin
              if (cur_n8) rbuf[8*unit +: 8]     <= dev_rdata[7:0];
              else        rbuf[16*unit[0] +: 16] <= dev_rdata;
            end
            pend <= pend & ~unit_bit;
            wcnt <= cur_wait;
            if (last_unit) st <= ST_RESP;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (st == ST_RESP);
  assign cpu_rdata = rbuf;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign dev_cs[g] = xfer && (cur_region == region_e'(g));
  end

  assign dev_rd    = xfer && !cur_we;
  assign dev_wr    = xfer && cur_we;
  assign dev_addr  = !xfer ? '0 :
                     cur_n8 ? {cur_word, unit} : {cur_word, unit[0], 1'b0};
  assign dev_wdata = !xfer ? '0 :
                     cur_n8 ? {8'h00, cur_wdata[8*unit +: 8]} : cur_wdata[16*unit[0] +: 16];
  assign dev_be    = !xfer ? 2'b00 :
                     cur_n8 ? 2'b01 : cur_be[2*unit[0] +: 2];

  // R11: chip-selects stay one-hot or idle
  a_r11_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_cs));

  // R11: read and write strobes never overlap
  a_r11_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));

  // R11: completion is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R5: a unit's outputs hold while its wait count runs
  a_r5_unit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wcnt != '0) |=> ($stable(dev_addr) && $stable(dev_cs) &&
                              $stable(dev_rd) && $stable(dev_wr) && $stable(dev_wdata)));

  // R8: the ROM is never written while flash-enable is clear
  a_r8_rom_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && dev_cs[0]) |-> flash_en);

  // R10: unused region answers next cycle with zero data
  a_r10_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.region == RG_NONE) |=> (cpu_ready && cpu_rdata == 32'h0 && dev_cs == '0));

endmodule

// File: tb/bwa_bridge_tb.sv
`timescale 1ns/1ps
module bwa_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic [23:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [4:0]  dev_cs;
  logic        dev_rd, dev_wr;
  logic [23:0] dev_addr;
  logic [1:0]  dev_be;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata;

  int total = 0;
  int bad = 0;
  logic [7:0] dmem   [5][256];
  logic [7:0] shadow [5][256];
  int cfg_wait [5];
  bit flash = 1'b0;

  always #4 clk = ~clk;

  bwa_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dev_cs(dev_cs), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_addr(dev_addr), .dev_be(dev_be), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  function automatic bit is8(input int r);
    return (r == 1) || (r == 3) || (r == 4);
  endfunction

  // R1 map, written from the requirement
  function automatic int region_of(input logic [23:0] a);
    case (a[23:20])
      4'h0, 4'h1: return 0;
      4'h2, 4'h3: return 1;
      4'h4:       return 5;
      4'h5:       return 2;
      4'h6, 4'h7: return 3;
      4'h8, 4'h9: return 4;
      default:    return 6;
    endcase
  endfunction

  // device model
  always_comb begin
    dev_rdata = 16'h0;
    for (int r = 0; r < 5; r++) begin
      if (dev_cs[r]) begin
        if (is8(r)) dev_rdata = {8'h00, dmem[r][dev_addr[7:0]]};
        else dev_rdata = {dmem[r][{dev_addr[7:1], 1'b1}], dmem[r][{dev_addr[7:1], 1'b0}]};
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 5; r++)
        for (int i = 0; i < 256; i++) dmem[r][i] <= 8'(r * 41 + i * 7 + 3);
    end else if (dev_wr) begin
      for (int r = 0; r < 5; r++) begin
        if (dev_cs[r]) begin
          if (is8(r)) dmem[r][dev_addr[7:0]] <= dev_wdata[7:0];
          else begin
            if (dev_be[0]) dmem[r][{dev_addr[7:1], 1'b0}] <= dev_wdata[7:0];
            if (dev_be[1]) dmem[r][{dev_addr[7:1], 1'b1}] <= dev_wdata[15:8];
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one request with per-clock comparison against the behavioural schedule
  task automatic access(input logic [23:0] a, input bit we, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
    int r, n, lat;
    int units[$];
    bit blocked;
    r = region_of(a);
    n = 0;
    blocked = 1'b0;
    if (r < 5) begin
      n = cfg_wait[r];
      if (we && r == 0 && !flash) blocked = 1'b1;
      if (!blocked) begin
        if (is8(r)) begin
          for (int i = 0; i < 4; i++) if (be[i]) units.push_back(i);
        end else begin
          for (int h = 0; h < 2; h++) if (be[2*h] || be[2*h+1]) units.push_back(h);
        end
      end
    end
    lat = units.size() * (1 + n) + 1;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; cpu_be = be; cpu_wdata = wd;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (c < lat) begin
        int u;
        string rq;
        u  = units[(c - 1) / (1 + n)];
        rq = is8(r) ? "R3" : "R2";
        chk("R5", "early ready", 32'(cpu_ready), 32'h0);
        chk("R1", "chip select", 32'(dev_cs), 32'(1 << r));
        chk(rq, "dev addr", 32'(dev_addr), 32'({a[23:2], 2'b00} + (is8(r) ? u : 2 * u)));
        chk("R5", "strobes", 32'({dev_rd, dev_wr}), we ? 32'h1 : 32'h2);
        if (we) begin
          if (is8(r)) begin
            chk(rq, "wdata", 32'(dev_wdata), 32'({8'h00, wd[8*u +: 8]}));
            chk(rq, "dev be", 32'(dev_be), 32'h1);
          end else begin
            chk(rq, "wdata", 32'(dev_wdata), 32'(wd[16*u +: 16]));
            chk(rq, "dev be", 32'(dev_be), 32'(be[2*u +: 2]));
          end
        end
      end else begin
        chk("R5", "ready at latency", 32'(cpu_ready), 32'h1);
        chk("R11", "device quiet", 32'({dev_cs, dev_rd, dev_wr}), 32'h0);
      end
    end
    rd = cpu_rdata;
    cpu_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [23:0] a, input logic [3:0] be, input string req);
    logic [31:0] got, exp;
    int r, idx, base;
    access(a, 1'b0, be, 32'h0, got);
    r = region_of(a);
    exp = '0;
    base = int'({a[7:2], 2'b00});
    if (r == 5) begin
      idx = int'(a[4:2]);
      if (idx < 5) exp = {28'h0, (idx == 0) && flash, 3'(cfg_wait[idx])};
    end else if (r < 5) begin
      for (int i = 0; i < 4; i++) begin
        if (is8(r)) begin
          if (be[i]) exp[8*i +: 8] = shadow[r][base + i];
        end else if (be[(i/2)*2] || be[(i/2)*2+1]) begin
          exp[8*i +: 8] = shadow[r][base + i];
        end
      end
    end
    chk(req, "read data", got, exp);
  endtask

  task automatic wr(input logic [23:0] a, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] dummy;
    int r, idx, base;
    r = region_of(a);
    base = int'({a[7:2], 2'b00});
    idx = int'(a[4:2]);
    if (r == 5) begin
      access(a, 1'b1, be, wd, dummy);
      if (be[0] && idx < 5) begin
        cfg_wait[idx] = int'(wd[2:0]);
        if (idx == 0) flash = wd[3];
      end
    end else begin
      bit blk;
      blk = (r == 0) && !flash;
      access(a, 1'b1, be, wd, dummy);
      if (r < 5 && !blk)
        for (int i = 0; i < 4; i++) if (be[i]) shadow[r][base + i] = wd[8*i +: 8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 5; r++) begin
      cfg_wait[r] = 7;
      for (int i = 0; i < 256; i++) shadow[r][i] = 8'(r * 41 + i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset ready", 32'(cpu_ready), 32'h0);
    chk("R11", "reset device idle", 32'({dev_cs, dev_rd, dev_wr}), 32'h0);

    // R7 reset values and unused offsets
    for (int k = 0; k < 5; k++) rd_chk(24'h400000 + 24'(4 * k), 4'hF, "R7");
    rd_chk(24'h400018, 4'hF, "R7");
    // slow access with reset waits (R5)
    rd_chk(24'h200010, 4'hF, "R5");

    // program waits; be[0]=0 write must be ignored (R7)
    wr(24'h400000, 4'hF, 32'h1);
    wr(24'h400004, 4'hF, 32'h0);
    wr(24'h400008, 4'hF, 32'h2);
    wr(24'h40000C, 4'hF, 32'h3);
    wr(24'h400004, 4'hE, 32'h5);
    rd_chk(24'h400004, 4'hF, "R7");
    rd_chk(24'h40000C, 4'hF, "R7");
    rd_chk(24'h400010, 4'hF, "R7");

    // 8-bit RAM
    rd_chk(24'h200020, 4'hF, "R3");
    wr(24'h200020, 4'hA, 32'hA1B2C3D4);
    rd_chk(24'h200020, 4'hF, "R3");
    rd_chk(24'h200020, 4'h5, "R6");
    rd_chk(24'h300044, 4'h8, "R1");

    // 16-bit peripheral area
    wr(24'h500030, 4'hF, 32'h11223344);
    wr(24'h500030, 4'h2, 32'h0000EE00);
    rd_chk(24'h500030, 4'hF, "R2");
    rd_chk(24'h500030, 4'hC, "R6");
    rd_chk(24'h500030, 4'h1, "R4");

    // external selects, long waits on B (R5)
    wr(24'h600008, 4'hF, 32'hCAFEF00D);
    rd_chk(24'h600008, 4'hF, "R5");
    wr(24'h800004, 4'hF, 32'h0BADBEEF);
    rd_chk(24'h800004, 4'hF, "R5");
    rd_chk(24'h900004, 4'h6, "R4");

    // zero byte enables (R4)
    rd_chk(24'h600008, 4'h0, "R4");
    wr(24'h600008, 4'h0, 32'hFFFFFFFF);
    rd_chk(24'h600008, 4'hF, "R4");

    // ROM protection (R8) then flash enable (R9)
    rd_chk(24'h000040, 4'hF, "R1");
    wr(24'h000040, 4'hF, 32'h55AA55AA);
    rd_chk(24'h000040, 4'hF, "R8");
    wr(24'h400000, 4'hF, 32'h9);
    rd_chk(24'h400000, 4'hF, "R7");
    wr(24'h000040, 4'hF, 32'h55AA55AA);
    rd_chk(24'h000040, 4'hF, "R9");
    wr(24'h100042, 4'hC, 32'h77660000);
    rd_chk(24'h100040, 4'hF, "R9");
    wr(24'h400000, 4'hF, 32'h1);
    wr(24'h000040, 4'h3, 32'h00001234);
    rd_chk(24'h000040, 4'hF, "R8");

    // unused region (R10)
    rd_chk(24'hA00004, 4'hF, "R10");
    wr(24'hA00004, 4'hF, 32'h12345678);
    rd_chk(24'hE00000, 4'hF, "R10");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule